// File: doc/BRIEF.md
# Translation Cache with Global Entries

This block keeps recent virtual-to-physical translations so that most memory accesses skip the page table walk. It is fully associative. Each slot holds either a 4 KB mapping or a 4 MB mapping. A lookup is combinational: it reports a hit with the physical address and the cached attribute bits, or it reports a miss, which sends the request to the walker.

The walker installs a finished translation through the refill port. It supplies the virtual address and the raw 32-bit table entry. Two maintenance operations keep the cache consistent with memory:

- A write of the table base register drops every mapping except those marked global.
- A single-page invalidate drops only the mapping or mappings that cover one virtual address.

Top module: `tlb_cache`

## Requirements
- R1: After reset no slot is valid and every lookup misses.
- R2: A 4 KB entry (entry bit 7 clear) hits when virtual bits 31..12 equal its tag. The returned address is the entry frame (entry bits 31..12) joined with virtual bits 11..0.
- R3: A 4 MB entry (entry bit 7 set) hits when virtual bits 31..22 equal its tag. The returned address is entry bits 31..22 joined with virtual bits 21..0.
- R4: On a hit, `lk_attr` carries cached entry bits as follows: [0] writable (entry bit 1), [1] user (bit 2), [2] write-through (bit 3), [3] cache-disable (bit 4), [4] dirty (bit 6), [5] global (bit 8). On a miss `lk_attr` is zero.
- R5: A write lookup that matches an entry whose dirty bit is clear reports a miss. A read lookup of the same entry hits.
- R6: A base-register write invalidates every entry whose global bit (entry bit 8) is clear and keeps every global entry.
- R7: A single-page invalidate removes every entry that covers the given address, global or not, and leaves all other entries valid.
- R8: Refill, base write and invalidate take effect at the next clock edge. A lookup in the same cycle as any of them reports a miss.
- R9: A refill whose address is already covered by a valid entry overwrites that entry in place instead of allocating a second slot.
- R10: A new refill goes to the lowest-numbered invalid slot. When every slot is valid, it goes to a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, each time it is used.
- R11: A refill whose entry has bit 0 (present) clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 6 | Cached attribute bits (see R4) |
| fill_en | input | 1 | Refill strobe |
| fill_va | input | 32 | Refill virtual address |
| fill_pte | input | 32 | Raw table entry to cache |
| base_wr | input | 1 | Table base register write: flush non-global entries |
| inval_en | input | 1 | Single-page invalidate strobe |
| inval_va | input | 32 | Address to invalidate |

## Verification
The hardest state to reach from the ports is a full cache whose round-robin pointer has already moved, with a hole opened by an invalidate. That state is needed to see that an invalid slot is preferred over the pointer and that the pointer does not move when it is not used. The stimulus fills every slot, then forces two evictions, invalidates one resident page and refills twice. Each following lookup identifies which page lost its slot. The in-place refill is checked on a full cache, where a wrongly allocated duplicate would be visible as an evicted neighbour.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_va,
  input  logic        lk_write,
  output logic        lk_hit,
  output logic [31:0] lk_pa,
  output logic [5:0]  lk_attr,
  input  logic        fill_en,
  input  logic [31:0] fill_va,
  input  logic [31:0] fill_pte,
  input  logic        base_wr,
  input  logic        inval_en,
  input  logic [31:0] inval_va
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid, big, glob, valid_nx;
  logic [19:0] vtag [ENTRIES];
  logic [19:0] pfn  [ENTRIES];
  logic [4:0]  attr [ENTRIES];
  logic [IW-1:0] rr;

  function automatic logic covers(input logic b, input logic [19:0] tag, input logic [31:0] va);
    return b ? (tag[19:10] == va[31:22]) : (tag == va[31:12]);
  endfunction

  logic [ENTRIES-1:0] lk_m, fill_m, inv_m;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_m[i]   = valid[i] && covers(big[i], vtag[i], lk_va);
      fill_m[i] = valid[i] && covers(big[i], vtag[i], fill_va);
      inv_m[i]  = valid[i] && covers(big[i], vtag[i], inval_va);
    end
  end

  logic          found;
  logic [IW-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (lk_m[i]) begin
        found = 1'b1;
        sel   = IW'(i);
      end
  end

  wire busy = fill_en | base_wr | inval_en;
  wire [4:0] sattr = attr[sel];
  assign lk_hit  = lk_valid && found && !busy && !(lk_write && !sattr[4]);
  assign lk_pa   = big[sel] ? {pfn[sel][19:10], lk_va[21:0]} : {pfn[sel], lk_va[11:0]};
  assign lk_attr = lk_hit ? {glob[sel], sattr} : 6'd0;

  wire fill_ok = fill_en && fill_pte[0];
  logic          any_inv, any_fm, use_rr;
  logic [IW-1:0] inv_slot, fm_slot, slot;
  always_comb begin
    any_inv = 1'b0; inv_slot = '0;
    any_fm  = 1'b0; fm_slot  = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!valid[i]) begin any_inv = 1'b1; inv_slot = IW'(i); end
      if (fill_m[i]) begin any_fm  = 1'b1; fm_slot  = IW'(i); end
    end
    use_rr = !any_fm && !any_inv;
    slot   = any_fm ? fm_slot : (any_inv ? inv_slot : rr);
  end

  always_comb begin
    valid_nx = valid;
    if (base_wr)  valid_nx = valid_nx & glob;
    if (inval_en) valid_nx = valid_nx & ~inv_m;
    if (fill_ok)  valid_nx[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      rr    <= '0;
    end else begin
      valid <= valid_nx;
      if (fill_ok && use_rr)
        rr <= (int'(rr) == ENTRIES-1) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      if (fill_ok && int'(slot) == i) begin
        vtag[i] <= fill_va[31:12];
        pfn[i]  <= fill_pte[31:12];
        big[i]  <= fill_pte[7];
        glob[i] <= fill_pte[8];
        attr[i] <= {fill_pte[6], fill_pte[4], fill_pte[3], fill_pte[2], fill_pte[1]};
      end
  end

  logic        past_ok, inv_q;
  logic [31:0] inv_q_va;
  logic [ENTRIES-1:0] inv_left;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      inv_q   <= inval_en && !fill_ok;
    end
    inv_q_va <= inval_va;
  end
  always_comb
    for (int i = 0; i < ENTRIES; i++)
      inv_left[i] = valid[i] && covers(big[i], vtag[i], inv_q_va);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> valid == '0);
  assert_dirty_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> lk_attr[4]);
  assert_flush_keeps_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && base_wr && !fill_ok) |=> (valid & ~glob) == '0);
  assert_inval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> inv_left == '0);
  assert_busy_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_hit);
  assert_fill_no_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fill_ok && !base_wr && !inval_en) |=> $countones(valid) >= $past($countones(valid)));
  assert_rr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rr) < ENTRIES);
  assert_absent_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fill_en && !fill_pte[0] && !base_wr && !inval_en) |=> $stable(valid));
endmodule

// File: tb/tlb_cache_tb_top.sv
module tlb_cache_tb_top;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_write = 0, fill_en = 0, base_wr = 0, inval_en = 0;
  logic [31:0] lk_va = 0, fill_va = 0, fill_pte = 0, inval_va = 0;
  logic lk_hit;
  logic [31:0] lk_pa;
  logic [5:0] lk_attr;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlb_cache #(.ENTRIES(8)) dut_i (.*);

  function automatic logic [31:0] pva(input int i);
    return 32'h0040_0000 + i * 32'h1000;
  endfunction
  function automatic logic [31:0] ppte(input int i, input logic g, input logic d);
    return {20'hA0000 + 20'(i * 7), 3'b0, g, 1'b0, d, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  endfunction
  function automatic logic [5:0] eattr(input logic [31:0] p);
    return {p[8], p[6], p[4], p[3], p[2], p[1]};
  endfunction

  task automatic rst();
    @(negedge clk); rst_n = 0; fill_en = 0; base_wr = 0; inval_en = 0; lk_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask
  task automatic fill(input logic [31:0] va, input logic [31:0] p);
    @(negedge clk); fill_en = 1; fill_va = va; fill_pte = p;
    @(negedge clk); fill_en = 0;
  endtask
  task automatic flush();
    @(negedge clk); base_wr = 1; @(negedge clk); base_wr = 0;
  endtask
  task automatic inval(input logic [31:0] va);
    @(negedge clk); inval_en = 1; inval_va = va; @(negedge clk); inval_en = 0;
  endtask
  task automatic check(input logic [31:0] va, input logic wr, input logic eh,
                       input logic [31:0] epa, input logic [5:0] ea, input string req);
    lk_valid = 1; lk_va = va; lk_write = wr; #2;
    checks++;
    if (lk_hit !== eh || (eh && (lk_pa !== epa || lk_attr !== ea)) || (!eh && lk_attr !== 6'd0)) begin
      errors++;
      $display("FAIL %s va=%h hit=%b pa=%h attr=%h expected hit=%b pa=%h attr=%h",
               req, va, lk_hit, lk_pa, lk_attr, eh, epa, ea);
    end
    lk_valid = 0; lk_write = 0;
  endtask
  task automatic hit_small(input int i, input logic g, input logic d, input logic [11:0] off, input string req);
    logic [31:0] p = ppte(i, g, d);
    check(pva(i) | off, 0, 1, {p[31:12], off}, eattr(p), req);
  endtask
  task automatic miss(input logic [31:0] va, input string req);
    check(va, 0, 0, 0, 0, req);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000 && !done) begin
        errors++; checks++; done = 1;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst();
    @(negedge clk);
    // R1: nothing cached after reset
    for (int i = 0; i < 8; i++) miss(pva(i), "R1");

    // R2/R4: 4 KB pages with offset sweep
    for (int i = 0; i < 8; i++) fill(pva(i), ppte(i, i[0], 1));
    for (int i = 0; i < 8; i++)
      for (int o = 0; o < 4096; o += 455) hit_small(i, i[0], 1, 12'(o), "R2");
    @(negedge clk);
    miss(pva(8), "R2");
    miss(pva(0) ^ 32'h8000_0000, "R2");

    // R3: large page
    rst();
    fill(32'h1234_5678, {10'h2A5, 10'h155, 12'h0C3});
    @(negedge clk);
    for (int k = 0; k < 22; k++) begin
      logic [31:0] va = {10'h048, 22'(1 << k) ^ 22'h0ABCDE};
      check(va, 0, 1, {10'h2A5, va[21:0]}, 6'b010001, "R3");
    end
    miss(32'h1274_5678, "R3");
    // R7: invalidate of large page through any address in its range
    inval(32'h123F_FFFF);
    @(negedge clk);
    miss(32'h1234_5678, "R7");

    // R5/R9: clean page refuses writes, refill in place on a full cache
    rst();
    for (int i = 0; i < 8; i++) fill(pva(i), ppte(i, 0, 1));
    fill(pva(3), ppte(3, 0, 0));
    @(negedge clk);
    hit_small(3, 0, 0, 12'h10, "R5");
    check(pva(3), 1, 0, 0, 0, "R5");
    fill(pva(3) | 32'h123, ppte(20, 0, 1));
    @(negedge clk);
    begin
      logic [31:0] p = ppte(20, 0, 1);
      check(pva(3) | 32'h44, 1, 1, {p[31:12], 12'h044}, eattr(p), "R9");
    end
    for (int i = 0; i < 8; i++) if (i != 3) hit_small(i, 0, 1, 12'h7, "R9");

    // R11: absent entry ignored
    rst();
    fill(pva(1), ppte(1, 0, 1) & ~32'h1);
    @(negedge clk);
    miss(pva(1), "R11");

    // R6/R7: flush keeps globals, invalidate is selective
    rst();
    for (int i = 0; i < 6; i++) fill(pva(i), ppte(i, (i == 1 || i == 4), 1));
    flush();
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      if (i == 1 || i == 4) hit_small(i, 1, 1, 12'h0, "R6");
      else miss(pva(i), "R6");
    inval(pva(1) | 32'hFFF);
    @(negedge clk);
    miss(pva(1), "R7");
    hit_small(4, 1, 1, 12'h9, "R7");
    rst();
    for (int i = 0; i < 6; i++) fill(pva(i), ppte(i, 0, 1));
    inval(pva(2));
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      if (i == 2) miss(pva(i), "R7"); else hit_small(i, 0, 1, 12'h3, "R7");

    // R8: same-cycle maintenance forces a miss
    @(negedge clk); fill_en = 1; fill_va = pva(6); fill_pte = ppte(6, 0, 1);
    check(pva(0), 0, 0, 0, 0, "R8");
    check(pva(6), 0, 0, 0, 0, "R8");
    @(negedge clk); fill_en = 0;
    hit_small(6, 0, 1, 12'h0, "R8");
    base_wr = 1; check(pva(1), 0, 0, 0, 0, "R8");
    @(negedge clk); base_wr = 0;
    miss(pva(1), "R8");
    fill(pva(1), ppte(1, 0, 1));
    @(negedge clk); inval_en = 1; inval_va = pva(9);
    check(pva(1), 0, 0, 0, 0, "R8");
    @(negedge clk); inval_en = 0;
    hit_small(1, 0, 1, 12'h0, "R8");

    // R10: replacement order
    rst();
    for (int i = 0; i < 8; i++) fill(pva(i), ppte(i, 0, 1));
    fill(pva(8), ppte(8, 0, 1));
    fill(pva(9), ppte(9, 0, 1));
    inval(pva(4));
    fill(pva(10), ppte(10, 0, 1));
    fill(pva(11), ppte(11, 0, 1));
    @(negedge clk);
    for (int i = 0; i < 12; i++)
      if (i == 0 || i == 1 || i == 2 || i == 4) miss(pva(i), "R10");
      else hit_small(i, 0, 1, 12'h5, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule